// File: doc/BRIEF.md
# Flag-Paced I2C Master Controller

This block is a single-master I2C controller behind a four-entry register window. Software writes a target address and a start request. The controller then puts a START condition and the address byte on the bus and moves data bytes one at a time. After every acknowledge slot it parks SCL low and raises status flags. The bus stays frozen until software writes zeros over the pending flag. Arming the force-stop control bit changes what the next release does: it ends the transfer with a STOP, and when reading it first takes one more byte that is answered with NACK.

The open-drain pads appear as two output enables, where 1 pulls the line low, plus a sampled SDA input. SCL timing comes from an external clock-enable pulse. A pin-override mode hands both lines straight to control bits.

Register window (`addr`): 0 = control, 1 = status, 2 = target, 3 = data. Control bits: 7 single-byte mode (stored only), 6 SCL level under override, 5 SDA level under override, 4 override enable, 3 master enable, 1 force stop, 0 start request. Status bits: 6 NACK seen, 5 arbitration lost, 4 STOP sent, 3 data register empty, 2 byte transmitted, 1 byte received, 0 address phase done; bit 7 reads 0. Target: bits [7:1] address, bit 0 direction (1 = read).

Top module: `i2c_flag_master`

## Requirements
- R1: After reset the control, status, target and data registers read 0 and both output enables are 0.
- R2: Control, target and data registers read back the value last written to them.
- R3: Writing the status register clears each bit written as 0, keeps each bit written as 1, and software can never set a status bit.
- R4: With control bit 4 set, scl_oe equals the inverse of control bit 6 and sda_oe equals the inverse of control bit 5, whatever the bus state.
- R5: A control write with bits 3 and 0 set produces a START (SDA falls while SCL is high) and then shifts the target register out MSB first, once per such write.
- R6: An acknowledged address byte sets status bit 0 plus bit 3 (write) or bit 1 (read); SCL is then held low until the pending flag (bit 3 writing, bit 1 reading) is written to 0.
- R7: In write mode, releasing the hold shifts out the data register MSB first; on ACK, status bits 2 and 3 are set.
- R8: In read mode, releasing the hold clocks in a byte, sets status bit 1 and makes it readable at the data register; the byte is answered with ACK, or with NACK when control bit 1 is set at that time.
- R9: Releasing the hold with control bit 1 set (in read mode: after a NACK-answered byte) generates STOP (SDA rises while SCL is high) and sets status bit 4.
- R10: A NACK on the address byte or a written byte sets status bit 6 and generates STOP, which sets status bit 4.
- R11: While control bit 3 is 0 (and bit 4 is 0), both lines are released, no START is issued and a pending transfer is abandoned.
- R12: If SDA reads low while the master releases it during a transmitted bit, status bit 5 is set and both lines are released.
- R13: The bus state advances only on a tick pulse; with tick held low, the lines stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bus phase clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
Register effects show on rdata the cycle after the write edge, and pin override follows control one cycle after the write. The bench samples these at the next falling clock edge. Bus results depend on ticks and a two-flop SDA synchronizer, so they take a variable number of cycles. For these the bench polls the status register until the flag that announces each phase appears, and only then compares data, flags and what the bench's target model captured. The bench checks the freeze under a held-low tick and the release under a disabled master over a fixed window of cycles.

// File: rtl/i2c_flag_master.sv
module i2c_flag_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [1:0] A_CTL = 2'd0, A_ST = 2'd1, A_TAR = 2'd2, A_DAT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_HOLD, S_STOP} state_t;
  state_t state;

  logic [7:0] ctl, tar, dat, sh;
  logic [6:0] st, st_set;
  logic [1:0] ph, sync;
  logic [2:0] cnt;
  logic       scl_q, sda_q, go, aphase, lnack;

  wire en   = ctl[3];
  wire ovr  = ctl[4];
  wire fsb  = ctl[1];
  wire rd   = tar[0];
  wire sda_s = sync[1];
  wire txb  = aphase || !rd;
  wire pend = rd ? st[1] : st[3];

  wire ack_done = en && tick && state == S_ACK && ph == 2'd2;
  wire nak  = ack_done && txb && sda_s;
  wire ok   = ack_done && !nak;
  wire arb  = en && tick && state == S_BIT && ph == 2'd2 && txb && !sda_q && !sda_s;
  wire stp  = en && tick && state == S_STOP && ph == 2'd2;

  assign st_set = {nak, arb, stp, ok && !rd, ok && !rd && !aphase, ok && rd, ok && aphase};
  assign scl_oe = ovr ? ~ctl[6] : scl_q;
  assign sda_oe = ovr ? ~ctl[5] : sda_q;

  always_comb
    case (addr)
      A_CTL:   rdata = ctl;
      A_ST:    rdata = {1'b0, st};
      A_TAR:   rdata = tar;
      default: rdata = dat;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0; tar <= '0; dat <= '0; st <= '0; sh <= '0;
      ph <= '0; cnt <= '0; sync <= 2'b11;
      scl_q <= 1'b0; sda_q <= 1'b0; go <= 1'b0; aphase <= 1'b0; lnack <= 1'b0;
      state <= S_IDLE;
    end else begin
      sync <= {sync[0], sda_in};
      if (wr_en && addr == A_CTL) ctl <= wdata;
      if (wr_en && addr == A_TAR) tar <= wdata;
      if (wr_en && addr == A_DAT) dat <= wdata;
      st <= ((wr_en && addr == A_ST) ? (st & wdata[6:0]) : st) | st_set;
      if (ok && rd && !aphase) dat <= sh;

      if (!en) begin
        state <= S_IDLE; scl_q <= 1'b0; sda_q <= 1'b0; ph <= '0; go <= 1'b0;
      end else if (tick) begin
        case (state)
          S_IDLE:
            if (go) begin
              state <= S_START; sda_q <= 1'b1; go <= 1'b0; lnack <= 1'b0;
            end
          S_START: begin
            scl_q <= 1'b1; sh <= tar; cnt <= 3'd7; aphase <= 1'b1; ph <= '0; state <= S_BIT;
          end
          S_BIT:
            case (ph)
              2'd0: begin sda_q <= txb ? ~sh[7] : 1'b0; ph <= 2'd1; end
              2'd1: begin scl_q <= 1'b0; ph <= 2'd2; end
              default:
                if (arb) begin
                  state <= S_IDLE; scl_q <= 1'b0; sda_q <= 1'b0; ph <= '0;
                end else begin
                  sh <= {sh[6:0], sda_s}; scl_q <= 1'b1; ph <= '0;
                  if (cnt == 3'd0) state <= S_ACK;
                  else cnt <= cnt - 3'd1;
                end
            endcase
          S_ACK:
            case (ph)
              2'd0: begin
                if (txb) sda_q <= 1'b0;
                else begin sda_q <= ~fsb; lnack <= fsb; end
                ph <= 2'd1;
              end
              2'd1: begin scl_q <= 1'b0; ph <= 2'd2; end
              default: begin
                scl_q <= 1'b1; ph <= '0;
                state <= nak ? S_STOP : S_HOLD;
              end
            endcase
          S_HOLD:
            if (!pend) begin
              ph <= '0;
              if (fsb && (!rd || lnack)) state <= S_STOP;
              else begin
                state <= S_BIT; cnt <= 3'd7; aphase <= 1'b0;
                sh <= rd ? 8'hFF : dat;
              end
            end
          default:
            case (ph)
              2'd0: begin sda_q <= 1'b1; ph <= 2'd1; end
              2'd1: begin scl_q <= 1'b0; ph <= 2'd2; end
              default: begin sda_q <= 1'b0; ph <= '0; state <= S_IDLE; end
            endcase
        endcase
      end
      if (wr_en && addr == A_CTL) go <= wdata[0] & wdata[3];
    end
endmodule

// File: rtl/i2c_flag_master_chk.sv
module i2c_flag_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_q,
  input logic [7:0] ctl,
  input logic [6:0] st,
  input logic [2:0] state
);
  localparam logic [2:0] C_IDLE = 3'd0, C_HOLD = 3'd4, C_STOP = 3'd5;

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[3] && !ctl[4] && !$past(ctl[3])) |-> (!scl_oe && !sda_oe)); // R11
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_HOLD && !ctl[4]) |-> scl_oe); // R6
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[4]) |-> $past(state) == C_STOP); // R9
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[6]) |-> state == C_STOP); // R10
  AST_ARB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[5]) |-> (state == C_IDLE && !scl_q)); // R12
  AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q != $past(scl_q)) |-> ($past(tick) || !$past(ctl[3]))); // R13
endmodule

bind i2c_flag_master i2c_flag_master_chk u_chk (.*);

// File: tb/i2c_flag_master_tb.sv
module i2c_flag_master_tb;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_CTL = 2'd0, A_ST = 2'd1, A_TAR = 2'd2, A_DAT = 2'd3;

  logic clk = 0, rst_n = 0, tick = 0, tick_on = 1, wr_en = 0, arb_pull = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic scl_oe, sda_oe;
  logic scl_line, sda_line;
  int ntest = 0, nfail = 0;
  int unsigned seed_r;

  logic s_sda_oe = 0, s_act = 0, s_rd = 0, s_mack = 0;
  int s_bitn = 0, s_byten = 0, s_starts = 0, s_stops = 0, s_nak_idx = -1;
  logic [7:0] s_sh = 0;
  logic [7:0] s_got [4];
  logic [7:0] s_tx [2];

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || s_sda_oe || arb_pull);

  i2c_flag_master u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    int tdiv;
    tdiv = 0;
    forever begin
      @(negedge clk);
      tdiv++;
      tick = tick_on && (tdiv % 4 == 0);
    end
  end

  initial begin
    logic ps, pc;
    ps = 1; pc = 1;
    forever begin
      @(sda_line or scl_line);
      if (scl_line && pc && ps && !sda_line) begin
        s_act = 1; s_bitn = 0; s_byten = 0; s_rd = 0; s_sda_oe = 0; s_starts++;
      end else if (scl_line && pc && !ps && sda_line) begin
        s_act = 0; s_sda_oe = 0; s_stops++;
      end else if (!pc && scl_line && s_act) begin
        if (s_bitn < 8) s_sh = {s_sh[6:0], sda_line};
        else if (s_bitn == 8) s_mack = sda_line;
        s_bitn++;
      end else if (pc && !scl_line && s_act) begin
        if (s_bitn == 8) begin
          if (s_byten == 0 || !s_rd) begin
            if (s_byten < 4) s_got[s_byten] = s_sh;
            if (s_byten == 0) s_rd = s_sh[0];
            s_sda_oe = (s_byten != s_nak_idx);
          end else s_sda_oe = 0;
        end else if (s_bitn == 9) begin
          s_byten++; s_bitn = 0;
          if (s_rd && !(s_byten > 1 && s_mack)) s_sda_oe = !s_tx[(s_byten-1)&1][7];
          else s_sda_oe = 0;
        end else if (s_rd && s_byten > 0 && !(s_byten > 1 && s_mack) && s_bitn < 8)
          s_sda_oe = !s_tx[(s_byten-1)&1][7-s_bitn];
      end
      ps = sda_line; pc = scl_line;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_st(input logic [7:0] m, input string tag);
    logic [7:0] v;
    int n;
    n = 0;
    do begin rd(A_ST, v); n++; end while ((v & m) != m && n < 5000);
    if ((v & m) != m) begin
      ntest++; nfail++;
      $display("FAIL %s timeout act=%h exp=%h", tag, v, m);
    end
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] v;
    int st0, sp0;
    st0 = s_starts; sp0 = s_stops; s_nak_idx = -1;
    wr(A_TAR, {a, 1'b0}); wr(A_DAT, d0); wr(A_ST, 0); wr(A_CTL, 8'h89);
    wait_st(8'h09, "R6");
    rd(A_ST, v); chk("R6 addr flags write", v, 8'h09);
    wr(A_CTL, 8'h88); wr(A_ST, 8'h76);
    wait_st(8'h08, "R7");
    rd(A_ST, v); chk("R7 byte flags", v, 8'h0C);
    wr(A_DAT, d1); wr(A_ST, 8'h77);
    wait_st(8'h08, "R7");
    wr(A_CTL, 8'h8A); wr(A_ST, 8'h77);
    wait_st(8'h10, "R9");
    rd(A_ST, v); chk("R9 stop flag", v, 8'h14);
    wr(A_CTL, 0);
    chk("R5 address byte", s_got[0], {a, 1'b0});
    chk("R7 byte0", s_got[1], d0);
    chk("R7 byte1", s_got[2], d1);
    chk("R5 one start", s_starts - st0, 1);
    chk("R9 one stop", s_stops - sp0, 1);
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n);
    logic [7:0] v;
    int sp0;
    sp0 = s_stops; s_nak_idx = -1;
    wr(A_TAR, {a, 1'b1}); wr(A_ST, 0); wr(A_CTL, 8'h89);
    wait_st(8'h03, "R6");
    rd(A_ST, v); chk("R6 addr flags read", v, 8'h03);
    wr(A_CTL, 8'h88);
    if (n == 1) wr(A_CTL, 8'h8A);
    wr(A_ST, 8'h7C);
    wait_st(8'h02, "R8");
    rd(A_DAT, v); chk("R8 rx byte0", v, s_tx[0]);
    chk("R8 answer byte0", s_mack, n == 1);
    if (n == 2) begin
      wr(A_CTL, 8'h8A); wr(A_ST, 8'h7D);
      wait_st(8'h02, "R8");
      rd(A_DAT, v); chk("R8 rx byte1", v, s_tx[1]);
      chk("R8 nack last", s_mack, 1);
    end
    wr(A_ST, 8'h7D);
    wait_st(8'h10, "R9");
    wr(A_CTL, 0);
    chk("R9 read stop", s_stops - sp0, 1);
    chk("R5 read address", s_got[0], {a, 1'b1});
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    ntest++; nfail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v, l0, l1;
    int st0, sp0;
    seed_r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    rd(A_ST, v);  chk("R1 status", v, 0);
    rd(A_TAR, v); chk("R1 target", v, 0);
    rd(A_DAT, v); chk("R1 data", v, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    wr(A_CTL, 8'h84); rd(A_CTL, v); chk("R2 ctl", v, 8'h84);
    wr(A_TAR, 8'h5B); rd(A_TAR, v); chk("R2 target", v, 8'h5B);
    wr(A_DAT, 8'hC3); rd(A_DAT, v); chk("R2 data", v, 8'hC3);
    wr(A_CTL, 0);
    wr(A_ST, 8'h7F); rd(A_ST, v); chk("R3 no sw set", v, 0);

    wr(A_CTL, 8'h50); @(negedge clk); chk("R4 ovr a", {scl_oe, sda_oe}, 2'b01);
    wr(A_CTL, 8'h30); @(negedge clk); chk("R4 ovr b", {scl_oe, sda_oe}, 2'b10);
    wr(A_CTL, 0);

    st0 = s_starts;
    wr(A_CTL, 8'h01); repeat (100) @(negedge clk);
    chk("R11 disabled lines", {scl_oe, sda_oe}, 0);
    wr(A_CTL, 8'h08); repeat (100) @(negedge clk);
    chk("R11 no start", s_starts - st0, 0);
    wr(A_CTL, 0);

    wr_txn(7'h2A, 8'hA5, 8'h3C);
    wr(A_ST, 8'h7B); rd(A_ST, v); chk("R3 clear bit2 keep bit4", v, 8'h10);
    wr(A_ST, 0);
    s_tx[0] = 8'h96;
    rd_txn(7'h51, 1);
    s_tx[0] = 8'h0F; s_tx[1] = 8'hE1;
    rd_txn(7'h13, 2);

    for (int i = 0; i < 6; i++) begin
      if ($urandom % 2) wr_txn(7'($urandom), 8'($urandom), 8'($urandom));
      else begin
        s_tx[0] = 8'($urandom); s_tx[1] = 8'($urandom);
        rd_txn(7'($urandom), 1 + int'($urandom % 2));
      end
    end

    sp0 = s_stops; s_nak_idx = 0;
    wr(A_TAR, 8'h44); wr(A_ST, 0); wr(A_CTL, 8'h89);
    wait_st(8'h10, "R10");
    rd(A_ST, v); chk("R10 addr nack", v, 8'h50);
    chk("R10 addr nack stop", s_stops - sp0, 1);
    wr(A_CTL, 0);

    sp0 = s_stops; s_nak_idx = 1;
    wr(A_TAR, 8'h44); wr(A_DAT, 8'h77); wr(A_ST, 0); wr(A_CTL, 8'h89);
    wait_st(8'h09, "R10");
    wr(A_CTL, 8'h88); wr(A_ST, 8'h76);
    wait_st(8'h10, "R10");
    rd(A_ST, v); chk("R10 data nack", v, 8'h50);
    chk("R10 data nack stop", s_stops - sp0, 1);
    wr(A_CTL, 0); s_nak_idx = -1;

    wr(A_ST, 0); wr(A_TAR, 8'hAA); wr(A_CTL, 8'h89);
    arb_pull = 1;
    wait_st(8'h20, "R12");
    rd(A_ST, v); chk("R12 arb flag", v, 8'h20);
    chk("R12 lines released", {scl_oe, sda_oe}, 0);
    arb_pull = 0;
    wr(A_CTL, 0); wr(A_ST, 0);

    wr(A_TAR, 8'h30); wr(A_CTL, 8'h89);
    while (!scl_oe) @(negedge clk);
    repeat (10) @(negedge clk);
    tick_on = 0;
    @(negedge clk);
    l0 = {6'd0, scl_oe, sda_oe};
    repeat (40) @(negedge clk);
    l1 = {6'd0, scl_oe, sda_oe};
    chk("R13 frozen", l1, l0);
    tick_on = 1;
    wait_st(8'h09, "R6");
    repeat (40) @(negedge clk);
    chk("R6 held low", scl_oe, 1);
    wr(A_CTL, 0); @(negedge clk);
    chk("R11 abandon", {scl_oe, sda_oe}, 0);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule